// File: doc/BRIEF.md
# Transceiver Low-Power Mode Controller

This block sequences a bus transceiver between three operating modes: normal (transmitter and receiver running), standby (bus quiet, supplies still enabled, wake monitoring active) and sleep (supply inhibit released). A host steers it through an active-low sleep-control input. In standby the block collects wake events and shows them to the host by holding the receive-data pin low. Three kinds of event count as a wake: a power-on-reset pulse, a wake-pattern pulse from the low-power bus receiver, and either edge on the local wake pin. A detected fault also pulls that pin low.

A fail-safe counter starts each time standby is entered. If the host does not select normal mode within `TIMEOUT` clock cycles, the block falls into sleep, where only a wake event brings it back to standby. The outputs are plain level controls for the analog part: a receive-pin override, a status pin, the transmit and receive enables, a bias select (ground or mid-supply) and the supply inhibit enable.

Top module: `trx_lpm_ctl`

## Requirements
- R1: While reset is asserted and afterwards until the first mode change, the block is in standby with the wake latch set, so `rxd_low`=1, `inh_en`=1, `sts`=0 and `bias_mid`=0 (ground bias). The local wake pin must be held low during reset.
- R2: In standby, `sts`, `tx_en` and `rx_en` are 0 and `inh_en` is 1. In normal mode, `sts`, `tx_en`, `rx_en`, `bias_mid` and `inh_en` are all 1.
- R3: With `slp_n`=1 in standby, the block enters normal mode at the next clock edge. With `slp_n`=0 in normal mode, it enters standby at the next clock edge. Both transitions clear the wake latch, the bias flag and the inactivity counter.
- R4: On entry to standby from normal mode, `bias_mid` is 0. A `bus_wake` pulse in standby sets `bias_mid` to 1 from the next edge, and it stays 1 until standby is left.
- R5: In standby, a wake event latches `rxd_low`=1 from the next edge until normal mode, sleep or reset.
- R6: `wake_pin` passes through a two-flop synchronizer and then an edge detector. A rising or falling change is acted on at the third clock edge after it.
- R7: A `por_pulse` in any mode puts the block in standby at the next edge with the wake latch set, the inactivity counter restarted, and `bias_mid` equal to `bus_wake` in that same cycle.
- R8: A high `fault` input in standby drives `rxd_low` to 1 in the same cycle, without waiting for a clock edge.
- R9: After `TIMEOUT` consecutive clock edges in standby with no `por_pulse` and no normal request, the block enters sleep. Non-POR wake events in standby do not restart the count.
- R10: In sleep, every output is 0 and `slp_n` is ignored. A wake event returns the block to standby at the next edge with `rxd_low`=1 and the counter restarted. If `bus_wake` is the event, `bias_mid` is set to 1.
- R11: In normal mode, `fault`, `bus_wake` and local wake edges have no effect: `rxd_low` stays 0 and the mode is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slp_n | input | 1 | Mode request: 1 selects normal, 0 selects standby |
| por_pulse | input | 1 | Power-on-reset pulse, one cycle |
| wake_pin | input | 1 | Local wake pin, asynchronous |
| bus_wake | input | 1 | Valid bus wake pattern seen by the low-power receiver, one cycle |
| fault | input | 1 | Fault flag |
| rxd_low | output | 1 | Forces the receive-data pin low |
| sts | output | 1 | Status pin, high only in normal mode |
| tx_en | output | 1 | Transmitter enable |
| rx_en | output | 1 | Receiver enable |
| bias_mid | output | 1 | Bus bias select: 1 = mid-supply, 0 = ground |
| inh_en | output | 1 | Supply inhibit enable |

## Verification
The hardest cases to reach from the ports are the ones where the timer and the wake logic meet. One is a bus wake arriving partway through standby, which must latch without restarting the counter. Another is a POR pulse in standby, which must restart it. The stimulus stays in standby for a counted number of cycles, injects one of these events at a known offset, and then confirms that the supply inhibit drops exactly `TIMEOUT` edges after the last restart. A behavioural reference model follows the same events and is compared against every output on every cycle. The directed checks also hold `slp_n` high during sleep to show that it is ignored.

// File: rtl/trx_lpm_ctl.sv
module trx_lpm_ctl #(
  parameter int TIMEOUT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slp_n,
  input  logic por_pulse,
  input  logic wake_pin,
  input  logic bus_wake,
  input  logic fault,
  output logic rxd_low,
  output logic sts,
  output logic tx_en,
  output logic rx_en,
  output logic bias_mid,
  output logic inh_en
);

  localparam int TW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
  localparam logic [TW-1:0] TLAST = TW'(TIMEOUT - 1);

  typedef enum logic [1:0] {M_NORM = 2'd0, M_STBY = 2'd1, M_SLP = 2'd2} mode_t;

  mode_t         mode;
  logic [TW-1:0] tmr;
  logic          wk_lat;
  logic          mid;
  logic [2:0]    lw_sync;
  logic          lw_edge;
  logic          wake_ev;

  assign lw_edge = lw_sync[1] ^ lw_sync[2];
  assign wake_ev = por_pulse | bus_wake | lw_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lw_sync <= '0;
    else        lw_sync <= {lw_sync[1:0], wake_pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode   <= M_STBY;
      tmr    <= '0;
      wk_lat <= 1'b1;
      mid    <= 1'b0;
    end else if (por_pulse) begin
      mode   <= M_STBY;
      tmr    <= '0;
      wk_lat <= 1'b1;
      mid    <= bus_wake;
    end else begin
      case (mode)
        M_NORM: if (!slp_n) begin
          mode   <= M_STBY;
          tmr    <= '0;
          wk_lat <= 1'b0;
          mid    <= 1'b0;
        end
        M_STBY: if (slp_n) begin
          mode   <= M_NORM;
          tmr    <= '0;
          wk_lat <= 1'b0;
          mid    <= 1'b0;
        end else if (tmr == TLAST) begin
          mode   <= M_SLP;
          tmr    <= '0;
          wk_lat <= 1'b0;
          mid    <= 1'b0;
        end else begin
          tmr <= tmr + TW'(1);
          if (wake_ev)  wk_lat <= 1'b1;
          if (bus_wake) mid    <= 1'b1;
        end
        M_SLP: if (wake_ev) begin
          mode   <= M_STBY;
          tmr    <= '0;
          wk_lat <= 1'b1;
          mid    <= bus_wake;
        end
        default: begin
          mode   <= M_STBY;
          tmr    <= '0;
          wk_lat <= 1'b1;
          mid    <= 1'b0;
        end
      endcase
    end
  end

  assign sts      = (mode == M_NORM);
  assign tx_en    = sts;
  assign rx_en    = sts;
  assign inh_en   = (mode != M_SLP);
  assign bias_mid = sts | ((mode == M_STBY) & mid);
  assign rxd_low  = (mode == M_STBY) & (wk_lat | fault);

endmodule

// File: rtl/trx_lpm_chk.sv
module trx_lpm_chk #(
  parameter int TIMEOUT = 64,
  parameter int TW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          slp_n,
  input logic          por_pulse,
  input logic          bus_wake,
  input logic          lw_edge,
  input logic [TW-1:0] tmr,
  input logic          sts,
  input logic          inh_en,
  input logic          bias_mid,
  input logic          rxd_low
);

  localparam logic [TW-1:0] TLAST = TW'(TIMEOUT - 1);

  logic        stby;
  logic [31:0] stby_cnt;

  assign stby = inh_en & ~sts;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                stby_cnt <= '0;
    else if (por_pulse | ~stby) stby_cnt <= '0;
    else                       stby_cnt <= stby_cnt + 32'd1;
  end

  assert_normal_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stby && slp_n && !por_pulse) |=> (sts && !rxd_low));

  assert_bus_wake_bias_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stby && !slp_n && !por_pulse && bus_wake && tmr != TLAST) |=> (bias_mid && rxd_low));

  assert_por_standby_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (por_pulse && !bus_wake) |=> (rxd_low && !sts && inh_en && !bias_mid));

  assert_timeout_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stby |-> (stby_cnt < TIMEOUT));

  assert_sleep_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!inh_en && !por_pulse && !bus_wake && !lw_edge) |=> (!inh_en && !sts));

  assert_normal_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sts && slp_n && !por_pulse) |=> (sts && !rxd_low));

endmodule

bind trx_lpm_ctl trx_lpm_chk #(.TIMEOUT(TIMEOUT), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .slp_n(slp_n), .por_pulse(por_pulse),
  .bus_wake(bus_wake), .lw_edge(lw_edge), .tmr(tmr), .sts(sts),
  .inh_en(inh_en), .bias_mid(bias_mid), .rxd_low(rxd_low)
);

// File: tb/tb_trx_lpm_ctl.sv
module tb_trx_lpm_ctl;
  localparam int TO = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slp_n = 1'b0, por_pulse = 1'b0, wake_pin = 1'b0, bus_wake = 1'b0, fault = 1'b0;
  logic rxd_low, sts, tx_en, rx_en, bias_mid, inh_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  trx_lpm_ctl #(.TIMEOUT(TO)) dut (
    .clk(clk), .rst_n(rst_n), .slp_n(slp_n), .por_pulse(por_pulse),
    .wake_pin(wake_pin), .bus_wake(bus_wake), .fault(fault),
    .rxd_low(rxd_low), .sts(sts), .tx_en(tx_en), .rx_en(rx_en),
    .bias_mid(bias_mid), .inh_en(inh_en)
  );

  // reference model: 0 normal, 1 standby, 2 sleep
  int m_mode, m_tmr;
  bit m_wk, m_mid;
  bit q [$];
  bit lw_prev;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 1; m_tmr = 0; m_wk = 1; m_mid = 0;
      q = '{1'b0, 1'b0}; lw_prev = 1'b0;
    end else begin
      bit edge_now, ev, front;
      front = q[0];
      edge_now = (front != lw_prev);
      ev = por_pulse || bus_wake || edge_now;
      lw_prev = front;
      void'(q.pop_front());
      q.push_back(wake_pin);
      if (por_pulse) begin
        m_mode = 1; m_tmr = 0; m_wk = 1; m_mid = bus_wake;
      end else if (m_mode == 0) begin
        if (!slp_n) begin m_mode = 1; m_tmr = 0; m_wk = 0; m_mid = 0; end
      end else if (m_mode == 1) begin
        if (slp_n) begin m_mode = 0; m_tmr = 0; m_wk = 0; m_mid = 0; end
        else if (m_tmr == TO - 1) begin m_mode = 2; m_tmr = 0; m_wk = 0; m_mid = 0; end
        else begin
          m_tmr++;
          if (ev) m_wk = 1;
          if (bus_wake) m_mid = 1;
        end
      end else if (ev) begin
        m_mode = 1; m_tmr = 0; m_wk = 1; m_mid = bus_wake;
      end
    end
  end

  task automatic chk(input logic act, input logic exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic cmp();
    chk(sts,      m_mode == 0, "R2", "sts");
    chk(tx_en,    m_mode == 0, "R2", "tx_en");
    chk(rx_en,    m_mode == 0, "R2", "rx_en");
    chk(bias_mid, (m_mode == 0) || (m_mode == 1 && m_mid), "R4", "bias_mid");
    chk(inh_en,   m_mode != 2, "R10", "inh_en");
    chk(rxd_low,  (m_mode == 1) && (m_wk || fault), "R5", "rxd_low");
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmp();
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1 actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    chk(rxd_low, 1'b1, "R1", "reset rxd_low");
    chk(inh_en,  1'b1, "R1", "reset inh_en");
    chk(sts,     1'b0, "R1", "reset sts");
    chk(bias_mid,1'b0, "R1", "reset bias");

    slp_n = 1'b1; step(1);
    chk(sts, 1'b1, "R3", "enter normal");
    chk(rxd_low, 1'b0, "R3", "latch cleared");

    fault = 1'b1; bus_wake = 1'b1; wake_pin = 1'b1; step(1);
    bus_wake = 1'b0; step(4);
    chk(rxd_low, 1'b0, "R11", "events ignored in normal");
    chk(sts, 1'b1, "R11", "stays normal");
    fault = 1'b0;

    slp_n = 1'b0; step(1);
    chk(sts, 1'b0, "R2", "standby sts");
    chk(inh_en, 1'b1, "R2", "standby inh");
    chk(bias_mid, 1'b0, "R4", "ground bias on entry");
    chk(rxd_low, 1'b0, "R3", "fresh standby no wake");

    fault = 1'b1; #1;
    chk(rxd_low, 1'b1, "R8", "fault drives rxd");
    fault = 1'b0; #1;
    chk(rxd_low, 1'b0, "R8", "fault release");
    step(1);

    bus_wake = 1'b1; step(1); bus_wake = 1'b0;
    chk(bias_mid, 1'b1, "R4", "mid bias after bus wake");
    chk(rxd_low, 1'b1, "R5", "bus wake latched");
    step(2);
    chk(rxd_low, 1'b1, "R5", "latch holds");

    slp_n = 1'b1; step(1); slp_n = 1'b0; step(1);
    chk(rxd_low, 1'b0, "R3", "normal cleared latch");
    wake_pin = 1'b0; step(2);
    chk(rxd_low, 1'b0, "R6", "falling edge not yet seen");
    step(1);
    chk(rxd_low, 1'b1, "R6", "falling edge latched");

    slp_n = 1'b1; step(1); slp_n = 1'b0; step(1);
    wake_pin = 1'b1; step(3);
    chk(rxd_low, 1'b1, "R6", "rising edge latched");

    slp_n = 1'b1; step(1); slp_n = 1'b0; step(1);
    step(30);
    bus_wake = 1'b1; step(1); bus_wake = 1'b0;
    step(32);
    chk(inh_en, 1'b1, "R9", "still standby before expiry");
    step(1);
    chk(inh_en, 1'b0, "R9", "sleep at expiry");
    chk(rxd_low, 1'b0, "R10", "sleep rxd released");

    slp_n = 1'b1; step(5);
    chk(sts, 1'b0, "R10", "slp_n ignored in sleep");
    chk(inh_en, 1'b0, "R10", "stays asleep");
    slp_n = 1'b0; bus_wake = 1'b1; step(1); bus_wake = 1'b0;
    chk(inh_en, 1'b1, "R10", "bus wake leaves sleep");
    chk(bias_mid, 1'b1, "R10", "mid bias after sleep wake");
    chk(rxd_low, 1'b1, "R10", "wake latched from sleep");

    step(64);
    chk(inh_en, 1'b0, "R9", "second expiry");
    wake_pin = 1'b0; step(3);
    chk(inh_en, 1'b1, "R6", "local wake leaves sleep");
    chk(rxd_low, 1'b1, "R10", "local wake latched");

    slp_n = 1'b1; step(1);
    por_pulse = 1'b1; step(1); por_pulse = 1'b0;
    chk(sts, 1'b0, "R7", "por forces standby");
    chk(rxd_low, 1'b1, "R7", "por latches rxd");
    slp_n = 1'b0; step(70);
    chk(inh_en, 1'b0, "R9", "sleep after por standby");
    por_pulse = 1'b1; step(1); por_pulse = 1'b0;
    chk(inh_en, 1'b1, "R7", "por wakes from sleep");
    chk(rxd_low, 1'b1, "R7", "por latch from sleep");

    step(40);
    por_pulse = 1'b1; step(1); por_pulse = 1'b0;
    step(40);
    chk(inh_en, 1'b1, "R7", "por restarted timer");
    step(30);
    chk(inh_en, 1'b0, "R9", "sleep after restarted count");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule